// File: doc/BRIEF.md
# Auxiliary SPI Master with Transmit and Receive FIFOs

This block is a compact SPI master for a peripheral subsystem. Software-visible configuration arrives as plain control inputs: the number of bits per transaction, the receive bit order, whether received bits concatenate onto the previous contents of the receive shifter, the number of extra SPI clocks the chip select stays high between transactions, the clock divider, and two interrupt enables. Data words enter through a four-entry transmit FIFO and leave through a four-entry receive FIFO, each 16 bits wide.

A transaction begins on its own whenever the interface is idle and the transmit FIFO holds a word. The word is shifted out on MOSI starting from bit 15. The incoming MISO bits are gathered in a 16-bit receive shifter that is pushed into the receive FIFO at the end of the transaction. A status group reports both FIFO levels, full and empty flags, a busy flag and a live count of the bits still to be shifted. One interrupt output combines the enabled conditions.

Top module: `aux_spi_master`

## Requirements
- R1: After reset stat_tx_empty and stat_rx_empty are 1, both levels, stat_tx_full, stat_busy and stat_bits_left are 0, cs_n is 1, sclk is 0 and rx_data is 0.
- R2: When idle with a non-empty transmit FIFO, the block pops one word, drives cs_n low and shifts out the word from bit 15 downward on MOSI. MOSI changes only on falling SCLK edges, MISO is sampled on rising edges, SCLK idles low and each SCLK half period lasts cfg_div+1 clock cycles. The transaction length is cfg_len bits for values 1 to 16, and 16 bits when cfg_len is 0 or above 16.
- R3: With cfg_msb_first=1 each sampled bit enters bit 0 of the receive shifter while the older bits move one place up, so the first bit of a 16-bit transfer ends at bit 15. With cfg_msb_first=0 each bit enters bit 15 while the older bits move one place down, so the first bit of a 16-bit transfer ends at bit 0.
- R4: With cfg_keep_rx=1 the receive shifter is not cleared when a transaction starts, so new bits concatenate onto the old contents. With cfg_keep_rx=0 it is zeroed at every start.
- R5: stat_bits_left loads the effective length when cs_n falls and decreases by one at each rising SCLK edge, reaching 0 at the end of the transfer.
- R6: Between back-to-back transactions cs_n stays high for exactly 2*(1+cfg_cs_extra)*(cfg_div+1)+1 clock cycles.
- R7: A push into the transmit FIFO is accepted only while stat_tx_full is 0. Otherwise it is dropped. stat_tx_full is 1 exactly when 4 words are held.
- R8: At the end of a transaction the receive shifter is pushed into the receive FIFO, and it is dropped if that FIFO already holds 4 words. rx_data shows the oldest word and reads 0 when the FIFO is empty.
- R9: stat_busy is 1 from the start of a transaction until the chip-select high time ends, and cs_n is high whenever stat_busy is 0.
- R10: irq is high when (cfg_irq_txe_en and the transmit FIFO is empty) or (cfg_irq_done_en and stat_busy is 0), and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 8 | SCLK half period minus one, in clock cycles |
| cfg_len | input | 6 | Bits per transaction (0 or >16 means 16) |
| cfg_msb_first | input | 1 | Receive bit order select |
| cfg_keep_rx | input | 1 | Keep receive shifter between transactions |
| cfg_cs_extra | input | 3 | Extra SPI clocks of chip-select high time |
| cfg_irq_txe_en | input | 1 | Interrupt on empty transmit FIFO |
| cfg_irq_done_en | input | 1 | Interrupt on idle interface |
| tx_push | input | 1 | Write tx_data into the transmit FIFO |
| tx_data | input | 16 | Word to transmit |
| rx_pop | input | 1 | Remove the oldest received word |
| rx_data | output | 16 | Oldest received word, 0 when empty |
| stat_tx_level | output | 3 | Words in the transmit FIFO |
| stat_rx_level | output | 3 | Words in the receive FIFO |
| stat_tx_full | output | 1 | Transmit FIFO full |
| stat_tx_empty | output | 1 | Transmit FIFO empty |
| stat_rx_empty | output | 1 | Receive FIFO empty |
| stat_busy | output | 1 | Transaction or chip-select high time in progress |
| stat_bits_left | output | 6 | Bits still to be shifted |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume the configuration inputs hold still while a transaction or chip-select hold is running, and that rx_pop is raised only while the receive FIFO has data. The bench changes configuration only after waiting for the transmit FIFO to drain and busy to drop. It raises rx_pop only on cycles where it has seen stat_rx_empty low. MISO is looped back from MOSI, directly or inverted, so every sampled bit is known in advance.

// File: rtl/aux_spi_pkg.sv
package aux_spi_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } spi_state_e;

  // Effective transfer length: 0 or anything above the word width means full word.
  function automatic logic [5:0] eff_len(input logic [5:0] len);
    if (len == 6'd0 || len > 6'(WORD_W)) return 6'(WORD_W);
    return len;
  endfunction

  // One receive step: msb_first shifts up and fills bit 0, otherwise shifts down and fills the top bit.
  function automatic logic [WORD_W-1:0] rx_merge(input logic [WORD_W-1:0] sh,
                                                 input logic bit_in,
                                                 input logic msb_first);
    if (msb_first) return {sh[WORD_W-2:0], bit_in};
    return {bit_in, sh[WORD_W-1:1]};
  endfunction
endpackage

// File: rtl/aux_spi_fifo.sv
module aux_spi_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] count;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    if (p == AW'(DEPTH-1)) return '0;
    return p + AW'(1);
  endfunction

  assign full    = (count == LW'(DEPTH));
  assign empty   = (count == '0);
  assign level   = count;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      if (do_push && !do_pop)      count <= count + LW'(1);
      else if (do_pop && !do_push) count <= count - LW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/aux_spi_shifter.sv
module aux_spi_shifter
  import aux_spi_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int HOLD_W = 3,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_msb_first,
  input  logic              cfg_keep_rx,
  input  logic [HOLD_W-1:0] cfg_cs_extra,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_take,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_put,
  output logic              ev_sample,
  output logic              busy,
  output logic [LEN_W-1:0]  bits_left,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  spi_state_e          state;
  logic [DIV_W-1:0]    hcnt;
  logic [HOLD_W:0]     halves;
  logic [WORD_W-1:0]   txsh, rxsh;
  logic                half_end;

  assign half_end  = (hcnt >= cfg_div);
  assign tx_take   = (state == ST_IDLE) && tx_valid;
  assign ev_sample = (state == ST_SHIFT) && half_end && !sclk;
  assign rx_put    = (state == ST_SHIFT) && half_end && sclk && (bits_left == '0);
  assign busy      = (state != ST_IDLE);
  assign rx_word   = rxsh;
  assign mosi      = cs_n ? 1'b0 : txsh[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      hcnt      <= '0;
      halves    <= '0;
      txsh      <= '0;
      rxsh      <= '0;
      bits_left <= '0;
      sclk      <= 1'b0;
      cs_n      <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          hcnt <= '0;
          if (tx_valid) begin
            txsh      <= tx_word;
            if (!cfg_keep_rx) rxsh <= '0;
            bits_left <= LEN_W'(eff_len(6'(cfg_len)));
            cs_n      <= 1'b0;
            state     <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (half_end) begin
            hcnt <= '0;
            if (!sclk) begin
              sclk      <= 1'b1;
              rxsh      <= rx_merge(rxsh, miso, cfg_msb_first);
              bits_left <= bits_left - LEN_W'(1);
            end else begin
              sclk <= 1'b0;
              if (bits_left == '0) begin
                cs_n   <= 1'b1;
                halves <= {cfg_cs_extra, 1'b1};
                state  <= ST_HOLD;
              end else begin
                txsh <= {txsh[WORD_W-2:0], 1'b0};
              end
            end
          end else begin
            hcnt <= hcnt + DIV_W'(1);
          end
        end
        ST_HOLD: begin
          if (half_end) begin
            hcnt <= '0;
            if (halves == '0) state <= ST_IDLE;
            else              halves <= halves - (HOLD_W+1)'(1);
          end else begin
            hcnt <= hcnt + DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_spi_master.sv
module aux_spi_master
  import aux_spi_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DIV_W  = 8,
  parameter int HOLD_W = 3,
  parameter int LEN_W  = 6,
  parameter int LVL_W  = $clog2(DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_msb_first,
  input  logic              cfg_keep_rx,
  input  logic [HOLD_W-1:0] cfg_cs_extra,
  input  logic              cfg_irq_txe_en,
  input  logic              cfg_irq_done_en,
  input  logic              tx_push,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              rx_pop,
  output logic [WORD_W-1:0] rx_data,
  output logic [LVL_W-1:0]  stat_tx_level,
  output logic [LVL_W-1:0]  stat_rx_level,
  output logic              stat_tx_full,
  output logic              stat_tx_empty,
  output logic              stat_rx_empty,
  output logic              stat_busy,
  output logic [LEN_W-1:0]  stat_bits_left,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n,
  output logic              irq
);
  logic [WORD_W-1:0] tx_head, rx_word;
  logic              tx_take, rx_put, ev_sample, rx_full_unused;

  aux_spi_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_data),
    .pop(tx_take), .dout(tx_head), .level(stat_tx_level),
    .full(stat_tx_full), .empty(stat_tx_empty)
  );

  aux_spi_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_put), .din(rx_word),
    .pop(rx_pop), .dout(rx_data), .level(stat_rx_level),
    .full(rx_full_unused), .empty(stat_rx_empty)
  );

  aux_spi_shifter #(.DIV_W(DIV_W), .HOLD_W(HOLD_W), .LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len(cfg_len),
    .cfg_msb_first(cfg_msb_first), .cfg_keep_rx(cfg_keep_rx),
    .cfg_cs_extra(cfg_cs_extra), .tx_valid(!stat_tx_empty), .tx_word(tx_head),
    .tx_take(tx_take), .rx_word(rx_word), .rx_put(rx_put), .ev_sample(ev_sample),
    .busy(stat_busy), .bits_left(stat_bits_left), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  assign irq = (cfg_irq_txe_en && stat_tx_empty) || (cfg_irq_done_en && !stat_busy);
endmodule

// File: rtl/aux_spi_master_chk.sv
module aux_spi_master_chk #(
  parameter int DEPTH = 4,
  parameter int LEN_W = 6,
  parameter int LVL_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              cs_n,
  input logic              sclk,
  input logic              ev_sample,
  input logic [LEN_W-1:0]  bits_left,
  input logic              tx_full,
  input logic              tx_empty,
  input logic [LVL_W-1:0]  tx_level,
  input logic              rx_empty,
  input logic [15:0]       rx_data,
  input logic              irq,
  input logic              txe_en,
  input logic              done_en
);
  p_sclk_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_bits_countdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sample |=> bits_left == $past(bits_left) - LEN_W'(1));

  p_full_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> tx_level == LVL_W'(DEPTH));

  p_empty_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> rx_data == 16'h0);

  p_cs_high_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  p_irq_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_en && !busy) |-> irq);

  p_irq_txe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (txe_en && tx_empty) |-> irq);
endmodule

bind aux_spi_master aux_spi_master_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(stat_busy), .cs_n(cs_n), .sclk(sclk),
  .ev_sample(ev_sample), .bits_left(stat_bits_left), .tx_full(stat_tx_full),
  .tx_empty(stat_tx_empty), .tx_level(stat_tx_level), .rx_empty(stat_rx_empty),
  .rx_data(rx_data), .irq(irq), .txe_en(cfg_irq_txe_en), .done_en(cfg_irq_done_en)
);

// File: tb/aux_spi_master_tb.sv
`timescale 1ns/1ps
module aux_spi_master_tb;
  logic        clk, rst_n;
  logic [7:0]  cfg_div;
  logic [5:0]  cfg_len;
  logic        cfg_msb_first, cfg_keep_rx;
  logic [2:0]  cfg_cs_extra;
  logic        cfg_irq_txe_en, cfg_irq_done_en;
  logic        tx_push, rx_pop;
  logic [15:0] tx_data, rx_data;
  logic [2:0]  stat_tx_level, stat_rx_level;
  logic        stat_tx_full, stat_tx_empty, stat_rx_empty, stat_busy;
  logic [5:0]  stat_bits_left;
  logic        sclk, mosi, miso, cs_n, irq;
  logic        inv_loop;

  int total = 0;
  int bad = 0;
  bit mon_en = 1;
  bit finished = 0;
  logic [15:0] sb_q[$];
  logic [15:0] model_sh = '0;
  int exp_len = 8;
  int last_gap = 0, last_hi = 0;

  assign miso = mosi ^ inv_loop;

  aux_spi_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len(cfg_len),
    .cfg_msb_first(cfg_msb_first), .cfg_keep_rx(cfg_keep_rx),
    .cfg_cs_extra(cfg_cs_extra), .cfg_irq_txe_en(cfg_irq_txe_en),
    .cfg_irq_done_en(cfg_irq_done_en), .tx_push(tx_push), .tx_data(tx_data),
    .rx_pop(rx_pop), .rx_data(rx_data), .stat_tx_level(stat_tx_level),
    .stat_rx_level(stat_rx_level), .stat_tx_full(stat_tx_full),
    .stat_tx_empty(stat_tx_empty), .stat_rx_empty(stat_rx_empty),
    .stat_busy(stat_busy), .stat_bits_left(stat_bits_left), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int len_of(input logic [5:0] l);
    return (l == 0 || l > 16) ? 16 : int'(l);
  endfunction

  // Independent receive model: bit i of a transfer is tx bit (15-i), optionally inverted.
  function automatic logic [15:0] model_rx(input logic [15:0] prev, input logic [15:0] tx,
                                           input int n, input bit msb, input bit keep, input bit inv);
    logic [15:0] r;
    r = keep ? prev : 16'h0;
    for (int i = 0; i < n; i++) begin
      logic b;
      b = tx[15-i] ^ inv;
      if (msb) r = {r[14:0], b};
      else     r = {b, r[15:1]};
    end
    return r;
  endfunction

  task automatic push_word(input logic [15:0] d, input bit rec);
    @(negedge clk);
    if (!stat_tx_full) begin
      model_sh = model_rx(model_sh, d, len_of(cfg_len), cfg_msb_first, cfg_keep_rx, inv_loop);
      if (rec) sb_q.push_back(model_sh);
    end
    tx_data = d;
    tx_push = 1'b1;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(stat_tx_empty && !stat_busy));
    repeat (8) @(negedge clk);
  endtask

  // Monitor: scoreboard pop, chip-select gap and SCLK high width measurement.
  initial begin
    int hi_cs = 0, hi_sc = 0;
    logic prev_cs = 1'b1;
    rx_pop = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (mon_en && !stat_rx_empty) begin
          if (sb_q.size() == 0) chk(0, "R8 unexpected rx word", 32'(rx_data), 0);
          else begin
            logic [15:0] e;
            e = sb_q.pop_front();
            chk(rx_data == e, "R2 R3 R4 rx word", 32'(rx_data), 32'(e));
          end
          rx_pop = 1'b1;
        end else rx_pop = 1'b0;
        if (cs_n) hi_cs++;
        else begin
          if (prev_cs) begin
            last_gap = hi_cs;
            chk(int'(stat_bits_left) == exp_len, "R5 bits_left at start", 32'(stat_bits_left), 32'(exp_len));
            chk(stat_busy == 1'b1, "R9 busy during transfer", 32'(stat_busy), 1);
          end
          hi_cs = 0;
        end
        prev_cs = cs_n;
        if (sclk) hi_sc++;
        else begin
          if (hi_sc != 0) last_hi = hi_sc;
          hi_sc = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tx_push = 0; tx_data = 0; inv_loop = 0;
    cfg_div = 8'd1; cfg_len = 6'd8; cfg_msb_first = 1; cfg_keep_rx = 0;
    cfg_cs_extra = 3'd0; cfg_irq_txe_en = 1; cfg_irq_done_en = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(stat_tx_empty && stat_rx_empty, "R1 empty flags", {stat_tx_empty, stat_rx_empty}, 3);
    chk(stat_tx_level == 0 && stat_rx_level == 0, "R1 levels", {stat_tx_level, stat_rx_level}, 0);
    chk(!stat_tx_full && !stat_busy && stat_bits_left == 0, "R1 busy/full/bits",
        {stat_tx_full, stat_busy, stat_bits_left}, 0);
    chk(cs_n && !sclk && rx_data == 0, "R1 pins", {cs_n, sclk, rx_data}, 32'h20000);
    chk(irq == 1'b1, "R10 irq idle", 32'(irq), 1);
    rst_n = 1;

    // R2 R3 msb-first, 8 bits, divider 1
    exp_len = 8;
    push_word(16'hA5C3, 1); push_word(16'h1234, 1); push_word(16'hFF00, 1);
    wait_idle();
    chk(sb_q.size() == 0, "R2 all words received", sb_q.size(), 0);
    chk(last_hi == 2, "R2 sclk half period", last_hi, 2);
    chk(!stat_busy && cs_n, "R9 idle after transfer", {stat_busy, cs_n}, 1);

    // R3 lsb-first, 12 bits, inverted loop
    cfg_msb_first = 0; inv_loop = 1; cfg_len = 6'd12; exp_len = 12;
    push_word(16'h8E71, 1); push_word(16'h0F0F, 1);
    wait_idle();
    chk(sb_q.size() == 0, "R3 lsb-first words", sb_q.size(), 0);

    // R4 keep input: 4-bit pieces concatenate
    cfg_msb_first = 1; inv_loop = 0; cfg_keep_rx = 1; cfg_len = 6'd4; exp_len = 4;
    push_word(16'hA000, 1); push_word(16'h5000, 1); push_word(16'hF000, 1);
    wait_idle();
    chk(sb_q.size() == 0, "R4 keep words", sb_q.size(), 0);
    cfg_msb_first = 0;
    push_word(16'h6000, 1); push_word(16'h9000, 1);
    wait_idle();
    chk(sb_q.size() == 0, "R4 keep lsb-first", sb_q.size(), 0);

    // R6 chip-select high time
    cfg_keep_rx = 0; cfg_msb_first = 1; cfg_div = 8'd2; cfg_cs_extra = 3'd5; cfg_len = 6'd3; exp_len = 3;
    push_word(16'hC000, 1); push_word(16'h4000, 1);
    wait_idle();
    chk(last_gap == 37, "R6 cs gap extra=5 div=2", last_gap, 37);
    chk(last_hi == 3, "R2 sclk half period div=2", last_hi, 3);
    cfg_div = 8'd0; cfg_cs_extra = 3'd0;
    push_word(16'hE000, 1); push_word(16'h2000, 1);
    wait_idle();
    chk(last_gap == 3, "R6 cs gap extra=0 div=0", last_gap, 3);

    // R2 length 0 means 16 bits
    cfg_len = 6'd0; exp_len = 16;
    push_word(16'h8001, 1);
    wait_idle();
    chk(sb_q.size() == 0, "R2 len0 as 16", sb_q.size(), 0);

    // R7 transmit full drop; R10 done-only irq while busy
    cfg_div = 8'd7; cfg_irq_txe_en = 0;
    for (int i = 0; i < 6; i++) push_word(16'h1111 * 16'(i + 1), 1);
    @(negedge clk);
    chk(stat_tx_level == 4 && stat_tx_full, "R7 tx full level", {stat_tx_level, stat_tx_full}, 9);
    chk(irq == 1'b0, "R10 irq low while busy", 32'(irq), 0);
    chk(stat_busy == 1'b1, "R9 busy", 32'(stat_busy), 1);
    wait_idle();
    chk(sb_q.size() == 0, "R7 five words, sixth dropped", sb_q.size(), 0);
    chk(irq == 1'b1, "R10 irq after done", 32'(irq), 1);

    // R8 receive full drop
    mon_en = 0; cfg_div = 8'd0; cfg_len = 6'd5; exp_len = 5;
    for (int i = 0; i < 5; i++) push_word(16'h9800 + 16'(i) * 16'h0800, i < 4);
    wait_idle();
    chk(stat_rx_level == 4 && !stat_rx_empty, "R8 rx held four", {stat_rx_level, stat_rx_empty}, 8);
    mon_en = 1;
    repeat (10) @(negedge clk);
    chk(sb_q.size() == 0, "R8 first four kept", sb_q.size(), 0);
    chk(stat_rx_empty && rx_data == 0, "R8 empty reads zero", 32'(rx_data), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule